// File: doc/BRIEF.md
# Line Noise Timer and Trace Monitor

This block watches the decoded line state of one physical link and measures how long the line stays away from Idle. A loadable down-counter is armed with a host-supplied maximum-noise value each time Idle ends. It then counts enable ticks until Idle returns. What happens when it runs out depends on the port state supplied by the surrounding port controller. In ACTIVE, an expiry asks the controller to break the link, or to enter TRACE if a trace request arrives in the same cycle. In MAINT, the timer is either a plain host-loadable register or a noise timer that raises an interrupt. In every other state an expiry has no effect.

The block also raises sticky, maskable, write-one-to-clear interrupt flags for received Master line state and for Quiet or Halt received during TRACE. While the port is in TRACE, it sources Master line state on the 5-bit transmit symbol path and signals that scrubbing is off. The port state machine and the line-state decoder sit outside this block.

Top module: `line_noise_monitor`

## Requirements
- R1: In the cycle after `ls_idle` was high and is now low, the timer loads `noise_max` and starts counting. While `ls_idle` is high, the timer holds its value and stops counting.
- R2: A running timer decreases by one on each cycle with `tick` high, if counting is permitted in the current state. It stays at zero once there. Expiry is a pulse lasting exactly the one cycle in which the count drops from 1 to 0, so a load value of 0 never expires.
- R3: Port state encoding is 0 = other, 1 = ACTIVE, 2 = MAINT, 3 = TRACE. In ACTIVE the timer only counts in cycles where `ls_flag` is high. In other and TRACE it counts without condition.
- R4: An expiry in ACTIVE with `trace_req` low drives `break_req` high in that same cycle.
- R5: An expiry in ACTIVE with `trace_req` high drives `trace_go` high and keeps `break_req` low.
- R6: `break_req` and `trace_go` are never high outside ACTIVE.
- R7: In MAINT with `noise_tmr_en` low, the timer does not count, and `host_tmr_wr` loads `host_tmr_data` and arms the timer. A host write in any other condition is ignored.
- R8: In MAINT with `noise_tmr_en` high, the timer counts noise, and an expiry sets flag bit 0 (timer expired).
- R9: Master line state (`ls_master`) received in ACTIVE or TRACE sets flag bit 1 (trace propagation).
- R10: Quiet or Halt line state received in TRACE sets flag bit 2 (self test).
- R11: Flags stay set until cleared. A one in `irq_clr` clears the matching flag on the next edge, and a new set in the same cycle wins over the clear. `irq_out` is the OR of `irq_flags & irq_mask`.
- R12: In TRACE, `scrub_off` is high and `tx_sym` alternates Halt (5'b00100) and Quiet (5'b00000), starting with Halt in the first TRACE cycle. Outside TRACE, `tx_sym` equals `tx_in` and `scrub_off` is low.
- R13: After reset, the timer is zero and stopped, all flags are clear, and `break_req`, `trace_go` and `irq_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer enable tick |
| ls_idle | input | 1 | Idle line state detected |
| ls_master | input | 1 | Master line state detected |
| ls_quiet | input | 1 | Quiet line state detected |
| ls_halt | input | 1 | Halt line state detected |
| ls_flag | input | 1 | Line-state flag qualifier for ACTIVE counting |
| trace_req | input | 1 | Trace request from the port controller |
| port_state | input | 2 | Current port state (0 other, 1 ACTIVE, 2 MAINT, 3 TRACE) |
| noise_tmr_en | input | 1 | Host bit: timer times noise in MAINT |
| noise_max | input | CNT_W | Maximum-noise reload value |
| host_tmr_wr | input | 1 | Host write strobe for the timer |
| host_tmr_data | input | CNT_W | Host write value for the timer |
| irq_mask | input | 3 | Interrupt enables per flag |
| irq_clr | input | 3 | Write-one-to-clear per flag |
| tx_in | input | 5 | Transmit symbol from upstream |
| break_req | output | 1 | Request transition to BREAK |
| trace_go | output | 1 | Request transition to TRACE |
| irq_flags | output | 3 | Sticky flags: 0 expired, 1 trace propagation, 2 self test |
| irq_out | output | 1 | Masked interrupt request |
| tx_sym | output | 5 | Transmit symbol to the line |
| scrub_off | output | 1 | Scrubbing disabled (TRACE) |

## Verification
The bench goes after cases where two events meet. One is an expiry with a trace request in the same cycle; a design that gives BREAK priority would raise `break_req` where `trace_go` is due. Another is Idle ending in the same cycle as a host write or a tick; a wrong priority shifts the expiry cycle, which the reference model catches. A load value of zero is also exercised, as is ACTIVE with the qualifier flag low. A timer that expired on loading zero, or counted without the flag, would raise spurious break requests. The bench also issues host writes outside MAINT; a design that accepted them would move the expiry.

// File: rtl/lnm_pkg.sv
package lnm_pkg;
   typedef enum logic [1:0] {
      PS_OTHER  = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_MAINT  = 2'd2,
      PS_TRACE  = 2'd3
   } port_st_e;

   localparam int IRQ_N      = 3;
   localparam int IRQ_EXPIRE = 0;
   localparam int IRQ_TPROP  = 1;
   localparam int IRQ_SELFT  = 2;
endpackage

// File: rtl/lnm_noise_timer.sv
module lnm_noise_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ls_idle,
   input  logic             count_ok,
   input  logic             host_load,
   input  logic [CNT_W-1:0] host_val,
   input  logic [CNT_W-1:0] max_val,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] count;
   logic             prev_idle;
   logic             running;
   logic             reload;
   logic             dec;

   assign reload = prev_idle & ~ls_idle;
   assign dec    = running & tick & count_ok & ~host_load & ~reload &
                   ~ls_idle & (count != ZERO);
   assign expire = dec & (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= ZERO;
         running   <= 1'b0;
         prev_idle <= 1'b0;
      end else begin
         prev_idle <= ls_idle;
         if (host_load) begin
            count   <= host_val;
            running <= 1'b1;
         end else if (reload) begin
            count   <= max_val;
            running <= 1'b1;
         end else if (ls_idle) begin
            running <= 1'b0;
         end else if (dec) begin
            count <= count - ONE;
         end
      end
   end

   AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire); // R2
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (count == ZERO && !host_load && !reload) |=> (count == ZERO)); // R2
   AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !host_load) |=> (count == $past(max_val))); // R1
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_idle && !host_load) |=> $stable(count)); // R1
endmodule

// File: rtl/lnm_expiry_router.sv
module lnm_expiry_router
   import lnm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  port_st_e st,
   input  logic     ls_flag,
   input  logic     noise_en,
   input  logic     host_wr,
   input  logic     trace_req,
   input  logic     expire,
   output logic     count_ok,
   output logic     host_load,
   output logic     break_req,
   output logic     trace_go,
   output logic     tne_set
);
   logic in_active;
   logic in_maint;

   assign in_active = (st == PS_ACTIVE);
   assign in_maint  = (st == PS_MAINT);

   always_comb begin
      unique case (st)
         PS_ACTIVE: count_ok = ls_flag;
         PS_MAINT:  count_ok = noise_en;
         default:   count_ok = 1'b1;
      endcase
   end

   assign host_load = host_wr & in_maint & ~noise_en;
   assign break_req = expire & in_active & ~trace_req;
   assign trace_go  = expire & in_active & trace_req;
   assign tne_set   = expire & in_maint & noise_en;

   AST_BREAK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (break_req || trace_go) |-> (st == PS_ACTIVE)); // R6
   AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(break_req && trace_go)); // R5
   AST_FLAG_GATES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_ACTIVE && !ls_flag) |-> !expire); // R3
   AST_MAINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_MAINT && !noise_en) |-> !expire); // R7
endmodule

// File: rtl/lnm_irq_bank.sv
module lnm_irq_bank #(
   parameter int N        = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] flags,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      if (SET_WINS) begin : g_setwin
         always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_i[i] | (flags[i] & ~clr_i[i]);
         end
      end else begin : g_clrwin
         always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] | set_i[i]) & ~clr_i[i];
         end
      end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr_i[i]) |=> flags[i]); // R11
   end

   assign irq = |(flags & mask_i);
endmodule

// File: rtl/lnm_tx_trace.sv
module lnm_tx_trace
   import lnm_pkg::*;
#(
   parameter int             SYM_W      = 5,
   parameter logic [SYM_W-1:0] HALT_SYM  = 5'b00100,
   parameter logic [SYM_W-1:0] QUIET_SYM = 5'b00000,
   parameter bit             ALT_MASTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  port_st_e         st,
   input  logic [SYM_W-1:0] tx_in,
   output logic [SYM_W-1:0] tx_sym,
   output logic             scrub_off
);
   logic in_trace;
   assign in_trace  = (st == PS_TRACE);
   assign scrub_off = in_trace;

   if (ALT_MASTER) begin : g_alt
      logic phase;
      always_ff @(posedge clk) begin
         if (!rst_n) phase <= 1'b0;
         else        phase <= in_trace ? ~phase : 1'b0;
      end
      assign tx_sym = in_trace ? (phase ? QUIET_SYM : HALT_SYM) : tx_in;

      AST_MASTER_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
         (in_trace && $past(st == PS_TRACE)) |-> (tx_sym != $past(tx_sym))); // R12
   end else begin : g_const
      assign tx_sym = in_trace ? HALT_SYM : tx_in;
   end

   AST_TRACE_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
      in_trace |-> (tx_sym == HALT_SYM || tx_sym == QUIET_SYM)); // R12
endmodule

// File: rtl/line_noise_monitor.sv
module line_noise_monitor
   import lnm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ls_idle,
   input  logic             ls_master,
   input  logic             ls_quiet,
   input  logic             ls_halt,
   input  logic             ls_flag,
   input  logic             trace_req,
   input  logic [1:0]       port_state,
   input  logic             noise_tmr_en,
   input  logic [CNT_W-1:0] noise_max,
   input  logic             host_tmr_wr,
   input  logic [CNT_W-1:0] host_tmr_data,
   input  logic [2:0]       irq_mask,
   input  logic [2:0]       irq_clr,
   input  logic [4:0]       tx_in,
   output logic             break_req,
   output logic             trace_go,
   output logic [2:0]       irq_flags,
   output logic             irq_out,
   output logic [4:0]       tx_sym,
   output logic             scrub_off
);
   localparam int SYM_W = 5;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("line_noise_monitor: CNT_W must lie in 2..32");
   end

   port_st_e         st;
   logic             count_ok;
   logic             host_load;
   logic             expire;
   logic             tne_set;
   logic [IRQ_N-1:0] irq_set;

   assign st = port_st_e'(port_state);

   lnm_noise_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ls_idle   (ls_idle),
      .count_ok  (count_ok),
      .host_load (host_load),
      .host_val  (host_tmr_data),
      .max_val   (noise_max),
      .expire    (expire)
   );

   lnm_expiry_router u_router (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .ls_flag   (ls_flag),
      .noise_en  (noise_tmr_en),
      .host_wr   (host_tmr_wr),
      .trace_req (trace_req),
      .expire    (expire),
      .count_ok  (count_ok),
      .host_load (host_load),
      .break_req (break_req),
      .trace_go  (trace_go),
      .tne_set   (tne_set)
   );

   always_comb begin
      irq_set             = '0;
      irq_set[IRQ_EXPIRE] = tne_set;
      irq_set[IRQ_TPROP]  = ls_master & (st == PS_ACTIVE || st == PS_TRACE);
      irq_set[IRQ_SELFT]  = (st == PS_TRACE) & (ls_quiet | ls_halt);
   end

   lnm_irq_bank #(.N(IRQ_N), .SET_WINS(1'b1)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_set),
      .clr_i  (irq_clr),
      .mask_i (irq_mask),
      .flags  (irq_flags),
      .irq    (irq_out)
   );

   lnm_tx_trace #(.SYM_W(SYM_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .tx_in     (tx_in),
      .tx_sym    (tx_sym),
      .scrub_off (scrub_off)
   );

   AST_TPROP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_master && (st == PS_ACTIVE || st == PS_TRACE)) |=> irq_flags[IRQ_TPROP]); // R9
   AST_SELFT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == PS_TRACE) && (ls_quiet || ls_halt)) |=> irq_flags[IRQ_SELFT]); // R10
   AST_TNE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && st == PS_MAINT && noise_tmr_en) |=> irq_flags[IRQ_EXPIRE]); // R8
endmodule

// File: tb/sim_line_noise_monitor.sv
module sim_line_noise_monitor;
   localparam int CW = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, tick, idle, master, quiet, halt, flag, trace;
   logic [1:0]    st;
   logic          en, wr;
   logic [CW-1:0] nmax, wdata;
   logic [2:0]    mask, clr;
   logic [4:0]    txin;
   logic          brk, tgo, irq, scrub;
   logic [2:0]    flags;
   logic [4:0]    txs;

   line_noise_monitor #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ls_idle(idle), .ls_master(master),
      .ls_quiet(quiet), .ls_halt(halt), .ls_flag(flag), .trace_req(trace),
      .port_state(st), .noise_tmr_en(en), .noise_max(nmax), .host_tmr_wr(wr),
      .host_tmr_data(wdata), .irq_mask(mask), .irq_clr(clr), .tx_in(txin),
      .break_req(brk), .trace_go(tgo), .irq_flags(flags), .irq_out(irq),
      .tx_sym(txs), .scrub_off(scrub)
   );

   int nchk = 0, nerr = 0;
   int n_brk = 0, n_tgo = 0, n_tne = 0;
   bit done = 1'b0;

   // reference model state
   logic [CW-1:0] m_cnt;
   logic          m_run, m_pidle, m_ph;
   logic [2:0]    m_flags;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic count_ok_f(logic [1:0] s, logic f, logic e);
      if (s == 2'd1) return f;       // R3 ACTIVE needs the qualifier
      if (s == 2'd2) return e;       // R7/R8 MAINT
      return 1'b1;
   endfunction

   function automatic logic [4:0] tx_exp_f(logic [1:0] s, logic ph, logic [4:0] ti);
      if (s == 2'd3) return ph ? 5'b00000 : 5'b00100; // R12
      return ti;
   endfunction

   task automatic step();
      logic hl, rl, dec, ex;
      logic [2:0] set;
      @(negedge clk);
      #1;
      hl  = wr && st == 2'd2 && !en;
      rl  = m_pidle && !idle;
      dec = m_run && tick && count_ok_f(st, flag, en) && !hl && !rl && !idle && (m_cnt != 0);
      ex  = dec && (m_cnt == 1);
      chk("R1/R2/R3/R4/R6 break_req", 32'(brk), 32'(ex && st == 2'd1 && !trace));
      chk("R5/R6 trace_go", 32'(tgo), 32'(ex && st == 2'd1 && trace));
      chk("R7/R8 flag0", 32'(flags[0]), 32'(m_flags[0]));
      chk("R9 flag1", 32'(flags[1]), 32'(m_flags[1]));
      chk("R10 flag2", 32'(flags[2]), 32'(m_flags[2]));
      chk("R11 irq_out", 32'(irq), 32'(|(m_flags & mask)));
      chk("R12 tx_sym", 32'(txs), 32'(tx_exp_f(st, m_ph, txin)));
      chk("R12 scrub_off", 32'(scrub), 32'(st == 2'd3));
      if (ex && st == 2'd1) begin if (trace) n_tgo++; else n_brk++; end
      if (ex && st == 2'd2 && en) n_tne++;
      set[0] = ex && st == 2'd2 && en;
      set[1] = master && (st == 2'd1 || st == 2'd3);
      set[2] = st == 2'd3 && (quiet || halt);
      m_flags = set | (m_flags & ~clr);
      if (hl) begin m_cnt = wdata; m_run = 1'b1; end
      else if (rl) begin m_cnt = nmax; m_run = 1'b1; end
      else if (idle) m_run = 1'b0;
      else if (dec) m_cnt = m_cnt - 1'b1;
      m_pidle = idle;
      m_ph = (st == 2'd3) ? ~m_ph : 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic quiet_inputs();
      tick = 0; idle = 0; master = 0; quiet = 0; halt = 0; flag = 1; trace = 0;
      wr = 0; wdata = '0; clr = 3'b000; txin = 5'h1b;
   endtask

   task automatic start_noise(logic [1:0] s, logic [CW-1:0] mx);
      st = s; nmax = mx; idle = 1; tick = 1;
      step();
      idle = 0;
   endtask

   initial begin
      rst_n = 0; st = 2'd0; en = 0; nmax = '0; mask = 3'b111;
      quiet_inputs();
      m_cnt = '0; m_run = 0; m_pidle = 0; m_ph = 0; m_flags = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      chk("R13 break_req", 32'(brk), 0);
      chk("R13 trace_go", 32'(tgo), 0);
      chk("R13 flags", 32'(flags), 0);
      chk("R13 irq_out", 32'(irq), 0);
      @(posedge clk); #1;

      // directed: ACTIVE break after 3 ticks
      start_noise(2'd1, 16'd3);
      repeat (5) step();
      // directed: expiry with trace request at the same cycle
      start_noise(2'd1, 16'd2);
      trace = 1;
      repeat (4) step();
      trace = 0;
      // directed: ACTIVE with qualifier low never expires
      start_noise(2'd1, 16'd1);
      flag = 0;
      repeat (4) step();
      flag = 1;
      // directed: load zero never expires
      start_noise(2'd1, 16'd0);
      repeat (4) step();
      // directed: MAINT host load then enable noise timing
      st = 2'd2; en = 0; wr = 1; wdata = 16'd2;
      step();
      wr = 0;
      repeat (3) step();
      en = 1;
      repeat (4) step();
      chk("R8 expired flag after enabled MAINT", 32'(flags[0]), 1);
      clr = 3'b001;
      step();
      clr = 3'b000;
      // directed: host write outside MAINT ignored
      start_noise(2'd0, 16'd4);
      wr = 1; wdata = 16'd1;
      repeat (6) step();
      wr = 0;
      // directed: TRACE sourcing, self test and trace propagation
      st = 2'd3; halt = 1; master = 1;
      step();
      halt = 0; master = 0;
      repeat (4) step();
      clr = 3'b110; quiet = 1;
      step();
      quiet = 0; clr = 3'b000;
      step();

      // constrained random
      void'($urandom(32'd20240611));
      for (int i = 0; i < 6000; i++) begin
         if (i % 40 == 0) begin
            st   = 2'($urandom_range(0, 3));
            en   = 1'($urandom_range(0, 1));
            nmax = CW'($urandom_range(0, 9));
            mask = 3'($urandom_range(0, 7));
         end
         tick   = ($urandom_range(0, 99) < 75);
         idle   = ($urandom_range(0, 99) < 8);
         flag   = ($urandom_range(0, 99) < 85);
         trace  = ($urandom_range(0, 99) < 20);
         master = ($urandom_range(0, 99) < 3);
         quiet  = ($urandom_range(0, 99) < 3);
         halt   = ($urandom_range(0, 99) < 3);
         wr     = ($urandom_range(0, 99) < 5);
         wdata  = CW'($urandom_range(0, 7));
         clr    = ($urandom_range(0, 99) < 10) ? 3'($urandom_range(0, 7)) : 3'b000;
         txin   = 5'($urandom_range(0, 31));
         step();
      end
      chk("R4 break requests seen", 32'(n_brk > 0), 1);
      chk("R5 trace requests seen", 32'(n_tgo > 0), 1);
      chk("R8 maint expiries seen", 32'(n_tne > 0), 1);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule